// File: doc/BRIEF.md
# Acquisition FIFO Level Flags and Interrupt Controller

This block buffers converted samples in a synchronous FIFO and tells the host how full that FIFO is. An acquisition engine pushes samples through a write strobe. The host pops samples and programs the block through a simple register port. Three active-low level flags report "holds data", "below half" and "has room". Software can read the fill state from those three bits without any counter.

Two interrupt causes are latched. One is the FIFO crossing up to half full. The other is a programmable sample count running out. Each cause has its own enable bit and its own clear bit in the control register. A single interrupt line is raised while any enabled cause is latched. Software services a cause by setting its clear bit and then writing it back to zero. A write into a full FIFO is dropped and leaves a sticky overflow indication. Stopping the FIFO empties it and discards that indication.

Top module: `acq_fifo_irq`

Register map (word addresses on `reg_addr`): 0 control (read/write, all 32 bits stored), 1 status (read only), 2 sample data (a read pops one sample), 3 sample counter (a write loads it, a read returns the remaining count), 4 interrupt status (read only). Read data appears on `reg_rdata` one clock after the read strobe.

## Requirements
- R1: After reset the status word reads not-empty bit 25 = 0, not-half bit 26 = 1, not-full bit 27 = 1 and overflow bit 30 = 0. The interrupt status word reads 0 and `irq` is 0.
- R2: Status bit 25 reads 1 while the FIFO holds at least one sample and 0 when it holds none.
- R3: Status bit 26 reads 0 while the FIFO holds 1024 or more of its 2048 entries, and 1 otherwise.
- R4: Status bit 27 reads 0 only when all 2048 entries are occupied. A full FIFO therefore shows bits 27:25 = 0,0,1.
- R5: Reads of address 2 return samples in write order, in the low 16 bits. A read of an empty FIFO returns 0 and does not change the fill state.
- R6: A write strobe into a full FIFO is dropped and sets status bit 30. Bit 30 stays set while samples are popped, and it clears only when the FIFO is stopped.
- R7: Control bit 7 runs the FIFO. While bit 7 is 0 the FIFO is held empty and write strobes are ignored.
- R8: The half-full cause, interrupt status bit 2, is latched on the transition of the fill level from below 1024 to 1024 or more. It stays latched after the level falls back below half.
- R9: The half-full cause requests an interrupt only while control bit 17 is 1. It is held cleared while control bit 18 is 1.
- R10: Writing N to address 3 arms a countdown. The Nth accepted sample after that latches the count-done cause, interrupt status bit 7. Further samples do not latch it again. Control bit 19 enables this cause, and it is held cleared while control bit 20 is 1.
- R11: `irq` is 1 exactly while some latched cause has its enable bit set. Clearing an enable bit masks the cause without discarding its latched state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid one cycle after `reg_rd` |
| acq_wr | input | 1 | Sample write strobe from the acquisition engine |
| acq_data | input | 16 | Sample value |
| irq | output | 1 | Interrupt request |

## Verification
A wrong fill count shows up in the three level bits on the very next status read. It also shows up in the sample order seen at the data address, so the bench reads both across the boundaries at 1, 1024 and 2048 entries. A missed or doubled edge in the half-full detector, or a wrong countdown, appears on `irq` and on the interrupt status word within two clocks of the sample that should cause it. A clear path that acts too early or too late leaves `irq` set after the set-then-clear pulse. The overflow bit is probed after popping and after stopping, so a flag with the wrong stickiness is reported on the first read that follows.

// File: rtl/acq_fifo_pkg.sv
package acq_fifo_pkg;

   typedef enum logic [2:0] {
      RA_CTRL = 3'd0,
      RA_STAT = 3'd1,
      RA_DATA = 3'd2,
      RA_SCNT = 3'd3,
      RA_IRQ  = 3'd4
   } reg_addr_e;

   // control bits
   localparam int unsigned CB_RUN    = 7;
   localparam int unsigned CB_HF_EN  = 17;
   localparam int unsigned CB_HF_CLR = 18;
   localparam int unsigned CB_SC_EN  = 19;
   localparam int unsigned CB_SC_CLR = 20;

   // status bits (active-low level flags)
   localparam int unsigned SB_NEMPTY = 25;
   localparam int unsigned SB_NHALF  = 26;
   localparam int unsigned SB_NFULL  = 27;
   localparam int unsigned SB_OVF    = 30;

   // interrupt status bits
   localparam int unsigned IB_HALF   = 2;
   localparam int unsigned IB_SCDONE = 7;

   // cause indices inside the cause vector
   localparam int unsigned NCAUSE  = 2;
   localparam int unsigned CI_HALF = 0;
   localparam int unsigned CI_SC   = 1;

endpackage

// File: rtl/acq_fifo_mem.sv
module acq_fifo_mem #(
   parameter int unsigned DW    = 16,
   parameter int unsigned DEPTH = 2048,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data
);

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rd_en) rd_data <= store[rd_addr];
   end

endmodule

// File: rtl/acq_fifo_level.sv
module acq_fifo_level #(
   parameter int unsigned DEPTH = 2048,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          push_req,
   input  logic          pop_req,
   output logic          push_ok,
   output logic          pop_ok,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_ptr,
   output logic          nempty,
   output logic          nhalf,
   output logic          nfull,
   output logic          half_lvl,
   output logic          ovf
);

   localparam logic [AW:0]   FULL_LVL = (AW+1)'(DEPTH);
   localparam logic [AW:0]   HALF_LVL = (AW+1)'(DEPTH / 2);
   localparam logic [AW:0]   CNT_ONE  = (AW+1)'(1);
   localparam logic [AW-1:0] PTR_ONE  = AW'(1);

   generate
      if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 4) begin : g_bad_depth
         $error("acq_fifo_level: DEPTH must be a power of two of at least 4");
      end
   endgenerate

   logic [AW:0] fill;
   logic        is_full;
   logic        is_empty;

   assign is_full  = (fill == FULL_LVL);
   assign is_empty = (fill == '0);
   assign push_ok  = run & push_req & ~is_full;
   assign pop_ok   = run & pop_req & ~is_empty;

   assign half_lvl = (fill >= HALF_LVL);
   assign nempty   = ~is_empty;
   assign nhalf    = ~half_lvl;
   assign nfull    = ~is_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill   <= '0;
         wr_ptr <= '0;
         rd_ptr <= '0;
         ovf    <= 1'b0;
      end else if (!run) begin
         fill   <= '0;
         wr_ptr <= '0;
         rd_ptr <= '0;
         ovf    <= 1'b0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + PTR_ONE;
         if (pop_ok)  rd_ptr <= rd_ptr + PTR_ONE;
         unique case ({push_ok, pop_ok})
            2'b10:   fill <= fill + CNT_ONE;
            2'b01:   fill <= fill - CNT_ONE;
            default: fill <= fill;
         endcase
         if (push_req && is_full) ovf <= 1'b1;
      end
   end

endmodule

// File: rtl/acq_sample_cnt.sv
module acq_sample_cnt #(
   parameter int unsigned CW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          tick,
   output logic [CW-1:0] remain,
   output logic          done
);

   localparam logic [CW-1:0] ONE = CW'(1);

   assign done = tick & ~load & (remain == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       remain <= '0;
      else if (load)                    remain <= load_val;
      else if (tick && remain != '0)    remain <= remain - ONE;
   end

endmodule

// File: rtl/acq_irq_cause.sv
module acq_irq_cause #(
   parameter int unsigned NC = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NC-1:0] cause_set,
   input  logic [NC-1:0] cause_clr,
   input  logic [NC-1:0] cause_en,
   output logic [NC-1:0] cause_q,
   output logic          irq
);

   generate
      if (NC < 1) begin : g_bad_nc
         $error("acq_irq_cause: NC must be at least 1");
      end
      for (genvar i = 0; i < NC; i++) begin : g_cause
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            cause_q[i] <= 1'b0;
            else if (cause_clr[i]) cause_q[i] <= 1'b0;
            else if (cause_set[i]) cause_q[i] <= 1'b1;
         end
      end
   endgenerate

   assign irq = |(cause_q & cause_en);

endmodule

// File: rtl/acq_fifo_irq.sv
module acq_fifo_irq
   import acq_fifo_pkg::*;
#(
   parameter int unsigned DW     = 16,
   parameter int unsigned DEPTH  = 2048,
   parameter int unsigned SCNT_W = 24,
   parameter int unsigned RW     = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    reg_addr,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [RW-1:0] reg_wdata,
   output logic [RW-1:0] reg_rdata,
   input  logic          acq_wr,
   input  logic [DW-1:0] acq_data,
   output logic          irq
);

   localparam int unsigned AW = $clog2(DEPTH);

   generate
      if (RW != 32) begin : g_bad_rw
         $error("acq_fifo_irq: register width must be 32");
      end
      if (DW > RW || SCNT_W > RW) begin : g_bad_dw
         $error("acq_fifo_irq: sample or counter width exceeds register width");
      end
   endgenerate

   // register decode
   logic [RW-1:0] ctrl_q;
   logic          wr_ctrl, wr_scnt, pop_req;

   assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
   assign wr_scnt = reg_wr && (reg_addr == RA_SCNT);
   assign pop_req = reg_rd && (reg_addr == RA_DATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= reg_wdata;
   end

   logic run, hf_en, hf_clr, sc_en, sc_clr;
   assign run    = ctrl_q[CB_RUN];
   assign hf_en  = ctrl_q[CB_HF_EN];
   assign hf_clr = ctrl_q[CB_HF_CLR];
   assign sc_en  = ctrl_q[CB_SC_EN];
   assign sc_clr = ctrl_q[CB_SC_CLR];

   // FIFO occupancy and storage
   logic          push_ok, pop_ok;
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          nempty, nhalf, nfull, half_lvl, ovf;
   logic [DW-1:0] mem_q;

   acq_fifo_level #(.DEPTH(DEPTH)) u_level (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .push_req (acq_wr),
      .pop_req  (pop_req),
      .push_ok  (push_ok),
      .pop_ok   (pop_ok),
      .wr_ptr   (wr_ptr),
      .rd_ptr   (rd_ptr),
      .nempty   (nempty),
      .nhalf    (nhalf),
      .nfull    (nfull),
      .half_lvl (half_lvl),
      .ovf      (ovf)
   );

   acq_fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
      .clk     (clk),
      .wr_en   (push_ok),
      .wr_addr (wr_ptr),
      .wr_data (acq_data),
      .rd_en   (pop_ok),
      .rd_addr (rd_ptr),
      .rd_data (mem_q)
   );

   // sample countdown
   logic [SCNT_W-1:0] scnt_remain;
   logic              sc_done;

   acq_sample_cnt #(.CW(SCNT_W)) u_scnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_scnt),
      .load_val (reg_wdata[SCNT_W-1:0]),
      .tick     (push_ok),
      .remain   (scnt_remain),
      .done     (sc_done)
   );

   // half-full rising edge
   logic half_d, hf_rise;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half_d <= 1'b0;
      else        half_d <= half_lvl;
   end
   assign hf_rise = half_lvl & ~half_d;

   // interrupt causes
   logic [NCAUSE-1:0] c_set, c_clr, c_en, cause_q;

   always_comb begin
      c_set = '0;
      c_clr = '0;
      c_en  = '0;
      c_set[CI_HALF] = hf_rise;
      c_set[CI_SC]   = sc_done;
      c_clr[CI_HALF] = hf_clr;
      c_clr[CI_SC]   = sc_clr;
      c_en[CI_HALF]  = hf_en;
      c_en[CI_SC]    = sc_en;
   end

   acq_irq_cause #(.NC(NCAUSE)) u_cause (
      .clk       (clk),
      .rst_n     (rst_n),
      .cause_set (c_set),
      .cause_clr (c_clr),
      .cause_en  (c_en),
      .cause_q   (cause_q),
      .irq       (irq)
   );

   // read path
   logic [RW-1:0] stat_w, irqs_w, reg_mux, reg_q;
   logic          sel_data_q, data_ok_q;

   always_comb begin
      stat_w            = '0;
      stat_w[SB_NEMPTY] = nempty;
      stat_w[SB_NHALF]  = nhalf;
      stat_w[SB_NFULL]  = nfull;
      stat_w[SB_OVF]    = ovf;
      irqs_w            = '0;
      irqs_w[IB_HALF]   = cause_q[CI_HALF];
      irqs_w[IB_SCDONE] = cause_q[CI_SC];
   end

   always_comb begin
      unique case (reg_addr)
         RA_CTRL: reg_mux = ctrl_q;
         RA_STAT: reg_mux = stat_w;
         RA_SCNT: reg_mux = RW'(scnt_remain);
         RA_IRQ:  reg_mux = irqs_w;
         default: reg_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_q      <= '0;
         sel_data_q <= 1'b0;
         data_ok_q  <= 1'b0;
      end else begin
         sel_data_q <= pop_req;
         data_ok_q  <= pop_ok;
         if (reg_rd) reg_q <= reg_mux;
      end
   end

   assign reg_rdata = sel_data_q ? (data_ok_q ? RW'(mem_q) : '0) : reg_q;

endmodule

// File: rtl/acq_fifo_irq_chk.sv
module acq_fifo_irq_chk (
   input logic clk,
   input logic rst_n,
   input logic acq_wr,
   input logic nempty,
   input logic nhalf,
   input logic nfull,
   input logic ovf,
   input logic run,
   input logic hf_en,
   input logic hf_clr,
   input logic sc_en,
   input logic sc_clr,
   input logic hf_cause,
   input logic sc_cause,
   input logic irq
);

   a_r4_full_flag_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      !nfull |-> (!nhalf && nempty));

   a_r3_half_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      !nhalf |-> nempty);

   a_r6_ovf_from_full_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf) |-> $past(acq_wr && !nfull));

   a_r7_stopped_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !nempty && !ovf);

   a_r8_half_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (hf_cause && !hf_clr) |=> hf_cause);

   a_r9_half_clear: assert property (@(posedge clk) disable iff (!rst_n)
      hf_clr |=> !hf_cause);

   a_r10_sc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      sc_clr |=> !sc_cause);

   a_r11_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (hf_en || sc_en));

endmodule

bind acq_fifo_irq acq_fifo_irq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .acq_wr   (acq_wr),
   .nempty   (nempty),
   .nhalf    (nhalf),
   .nfull    (nfull),
   .ovf      (ovf),
   .run      (run),
   .hf_en    (hf_en),
   .hf_clr   (hf_clr),
   .sc_en    (sc_en),
   .sc_clr   (sc_clr),
   .hf_cause (cause_q[0]),
   .sc_cause (cause_q[1]),
   .irq      (irq)
);

// File: tb/acq_fifo_irq_tb.sv
module acq_fifo_irq_tb;

   localparam logic [31:0] RUN    = 32'h1 << 7;
   localparam logic [31:0] HF_EN  = 32'h1 << 17;
   localparam logic [31:0] HF_CLR = 32'h1 << 18;
   localparam logic [31:0] SC_EN  = 32'h1 << 19;
   localparam logic [31:0] SC_CLR = 32'h1 << 20;

   localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_DATA = 3'd2,
                          A_SCNT = 3'd3, A_IRQ = 3'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        acq_wr = 1'b0;
   logic [15:0] acq_data = '0;
   logic        irq;

   int n_chk = 0;
   int n_err = 0;
   bit done_flag = 1'b0;

   always #10 clk = ~clk;

   acq_fifo_irq u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_rd    (reg_rd),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .acq_wr    (acq_wr),
      .acq_data  (acq_data),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic push(input logic [15:0] v);
      @(negedge clk);
      acq_wr = 1'b1; acq_data = v;
      @(negedge clk);
      acq_wr = 1'b0;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   // returns {ovf, nfull, nhalf, nempty}
   task automatic flags(output logic [3:0] f);
      logic [31:0] s;
      reg_read(A_STAT, s);
      f = {s[30], s[27], s[26], s[25]};
   endtask

   task automatic t_reset();
      logic [3:0] f; logic [31:0] d;
      flags(f);
      check("R1 status after reset", {28'd0, f}, 32'b0110);
      reg_read(A_IRQ, d);
      check("R1 irq status after reset", d, 32'h0);
      check("R1 irq pin after reset", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_stopped();
      logic [3:0] f;
      reg_write(A_CTRL, 32'h0);
      push(16'h1234);
      flags(f);
      check("R7 write ignored while stopped", {28'd0, f}, 32'b0110);
   endtask

   task automatic t_basic();
      logic [3:0] f; logic [31:0] d;
      reg_write(A_CTRL, RUN);
      push(16'hA001); push(16'hA002); push(16'hA003);
      flags(f);
      check("R2 not-empty with data", {28'd0, f}, 32'b0111);
      reg_read(A_DATA, d); check("R5 first sample", d, 32'hA001);
      reg_read(A_DATA, d); check("R5 second sample", d, 32'hA002);
      reg_read(A_DATA, d); check("R5 third sample", d, 32'hA003);
      reg_read(A_DATA, d); check("R5 empty read returns 0", d, 32'h0);
      flags(f);
      check("R2 empty after drain", {28'd0, f}, 32'b0110);
   endtask

   task automatic t_half();
      logic [3:0] f; logic [31:0] d;
      reg_write(A_CTRL, RUN | HF_EN);
      for (int i = 0; i < 1023; i++) push(16'(i));
      settle();
      flags(f);
      check("R3 below half at 1023", {28'd0, f}, 32'b0111);
      check("R8 no irq below half", {31'd0, irq}, 32'd0);
      push(16'd1023);
      settle();
      flags(f);
      check("R3 half at 1024", {28'd0, f}, 32'b0101);
      check("R8 irq on half crossing", {31'd0, irq}, 32'd1);
      reg_read(A_IRQ, d);
      check("R8 half cause bit 2", d, 32'h4);
      reg_read(A_DATA, d);
      check("R5 oldest sample at half", d, 32'h0);
      settle();
      flags(f);
      check("R3 back below half", {28'd0, f}, 32'b0111);
      check("R8 cause persists below half", {31'd0, irq}, 32'd1);
      reg_write(A_CTRL, RUN);
      settle();
      check("R11 irq masked", {31'd0, irq}, 32'd0);
      reg_read(A_IRQ, d);
      check("R11 latched while masked", d, 32'h4);
      reg_write(A_CTRL, RUN | HF_EN);
      settle();
      check("R11 irq back on unmask", {31'd0, irq}, 32'd1);
      reg_write(A_CTRL, RUN | HF_EN | HF_CLR);
      reg_write(A_CTRL, RUN | HF_EN);
      settle();
      check("R9 irq after clear pulse", {31'd0, irq}, 32'd0);
      reg_read(A_IRQ, d);
      check("R9 cause cleared", d, 32'h0);
   endtask

   task automatic t_full();
      logic [3:0] f; logic [31:0] d;
      for (int i = 1024; i <= 2048; i++) push(16'(i));
      settle();
      flags(f);
      check("R4 full pattern", {28'd0, f}, 32'b0001);
      push(16'hBEEF);
      flags(f);
      check("R6 overflow on full write", {28'd0, f}, 32'b1001);
      reg_read(A_DATA, d);
      check("R6 head intact after drop", d, 32'h1);
      flags(f);
      check("R6 overflow sticky after pop", {28'd0, f}, 32'b1101);
      reg_write(A_CTRL, 32'h0);
      flags(f);
      check("R7 stop empties and clears overflow", {28'd0, f}, 32'b0110);
   endtask

   task automatic t_count();
      logic [31:0] d;
      reg_write(A_CTRL, RUN | HF_CLR | SC_CLR);
      reg_write(A_CTRL, RUN | SC_EN);
      reg_write(A_SCNT, 32'd5);
      for (int i = 0; i < 4; i++) push(16'(i));
      settle();
      check("R10 no irq before count", {31'd0, irq}, 32'd0);
      reg_read(A_IRQ, d);
      check("R10 cause clear before count", d, 32'h0);
      push(16'd4);
      settle();
      check("R10 irq at count", {31'd0, irq}, 32'd1);
      reg_read(A_IRQ, d);
      check("R10 count-done bit 7", d, 32'h80);
      reg_read(A_SCNT, d);
      check("R10 remaining zero", d, 32'h0);
      reg_write(A_CTRL, RUN | SC_EN | SC_CLR);
      reg_write(A_CTRL, RUN | SC_EN);
      settle();
      check("R10 irq after clear pulse", {31'd0, irq}, 32'd0);
      push(16'd5);
      settle();
      check("R10 no retrigger after count", {31'd0, irq}, 32'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_flag) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_stopped();
      t_basic();
      t_half();
      t_full();
      t_count();
      done_flag = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule